// File: doc/BRIEF.md
# Edge-sequence timing monitor

This block watches three single-bit inputs, outer, mid and inner, on every rising edge of the system clock. It checks that they move in a nested order and that each move keeps a minimum distance in clock cycles from the one before it. The expected order is outer rising, mid rising, inner rising, inner falling, mid falling and finally outer falling. That order forms five timed steps, and each step has its own minimum gap parameter.

A complete and well-spaced sequence produces a one-cycle pass pulse. A next edge that comes in the right order but too soon produces a one-cycle error pulse, together with the index of the step that failed. If the order is broken before the sequence finishes, the check is dropped. It then produces a one-cycle abort pulse and raises no error. The monitor only sees the inputs at clock edges, so a pulse that starts and ends between two samples is invisible to it. After any of the three pulses the monitor goes back to idle and waits for outer to rise again.

Top module: `edge_seq_monitor`

## Requirements
- R1: A sequence in the order outer rise, mid rise, inner rise, inner fall, mid fall, outer fall, with every gap met, raises pass_o for one cycle. The pulse appears in the cycle after the clock edge that samples outer low.
- R2: The gap of a step is the number of clock edges from the edge that sampled the previous accepted change to the edge that samples this change. The step is accepted when the gap is greater than or equal to its parameter, so a gap exactly equal to the parameter is accepted.
- R3: An edge that comes in order but with a gap below its parameter raises err_o for one cycle and returns the monitor to idle. At the same time err_step_o gives the step: 0 mid rise, 1 inner rise, 2 inner fall, 3 mid fall, 4 outer fall. When err_o is low, err_step_o is 0.
- R4: An outer fall before inner has risen, or a mid fall before inner has risen, raises abort_o for one cycle, never err_o, and returns the monitor to idle.
- R5: While a sequence runs, abort_o is raised instead of any timing check whenever a change other than the single expected one is sampled. This includes inner rising before mid, mid falling while inner is high, and two inputs changing on the same edge.
- R6: In idle, only an outer rise sampled while mid and inner are both low starts a sequence. Every other change in idle produces no pulse and starts nothing.
- R7: The gap counter saturates at its maximum and does not wrap. A gap far longer than the counter range is therefore still accepted.
- R8: pass_o, err_o and abort_o are single-cycle pulses, and at most one of them is high in any cycle.
- R9: While rst_ni is low, all outputs are low. The input levels present when reset is released are taken as the starting levels, so inputs that are already high at release do not count as edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; inputs sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| outer_i | input | 1 | Outermost signal of the nested sequence |
| mid_i | input | 1 | Middle signal of the nested sequence |
| inner_i | input | 1 | Innermost signal of the nested sequence |
| pass_o | output | 1 | One-cycle pulse: sequence completed with all gaps met |
| err_o | output | 1 | One-cycle pulse: an in-order edge came too early |
| abort_o | output | 1 | One-cycle pulse: order broken, check abandoned |
| err_step_o | output | 3 | Index of the failing step while err_o is high, else 0 |

## Verification
The embedded assertions check, on every cycle, the following properties:
- the three pulses are mutually exclusive and last one cycle each;
- the gap counter clears after an accepted edge and holds at saturation;
- an error always reports a step index in range;
- a pass always follows outer falling;
- changes other than an outer rise leave the idle state unchanged.

Some properties only the bench scenarios can show. One is that the accept or reject boundary sits exactly at each step's parameter, which the bench shows by sweeping the gap of every step around its limit. Another is that each abort case wins over timing. A third is that very long gaps survive saturation. The last is that high levels present at reset release are never counted as edges.

// File: rtl/edge_seq_pkg.sv
`timescale 1ns/1ps
package edge_seq_pkg;

  localparam int NUM_SIG   = 3;  // 0 outer, 1 mid, 2 inner
  localparam int NUM_STEPS = 5;
  localparam int STEP_W    = 3;
  localparam int EV_W      = 2 * NUM_SIG;  // {fall[2:0], rise[2:0]}

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_W_MID_R = 3'd1,
    ST_W_IN_R  = 3'd2,
    ST_W_IN_F  = 3'd3,
    ST_W_MID_F = 3'd4,
    ST_W_OUT_F = 3'd5
  } seq_state_e;

  // one-hot event bit expected in each waiting state
  function automatic logic [EV_W-1:0] expected_ev(seq_state_e s);
    case (s)
      ST_W_MID_R: expected_ev = 6'b000010;
      ST_W_IN_R:  expected_ev = 6'b000100;
      ST_W_IN_F:  expected_ev = 6'b100000;
      ST_W_MID_F: expected_ev = 6'b010000;
      ST_W_OUT_F: expected_ev = 6'b001000;
      default:    expected_ev = '0;
    endcase
  endfunction

endpackage

// File: rtl/edge_seq_edge.sv
`timescale 1ns/1ps
module edge_seq_edge #(
  parameter int WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic             primed_q;
  logic [WIDTH-1:0] prev_q;

  // first edge after reset only captures levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      prev_q   <= '0;
    end else begin
      primed_q <= 1'b1;
      prev_q   <= sig_i;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign rise_o[i] = primed_q &  sig_i[i] & ~prev_q[i];
    assign fall_o[i] = primed_q & ~sig_i[i] &  prev_q[i];
  end

endmodule

// File: rtl/edge_seq_gap_cnt.sv
`timescale 1ns/1ps
module edge_seq_gap_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 count_q <= '0;
    else if (clear_i)            count_q <= '0;
    else if (count_q != CNT_MAX) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;

  a_r7_saturate_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CNT_MAX && !clear_i) |=> (count_q == CNT_MAX));

  a_r2_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_q == '0));

endmodule

// File: rtl/edge_seq_fsm.sv
`timescale 1ns/1ps
module edge_seq_fsm
  import edge_seq_pkg::*;
#(
  parameter int CNT_W        = 3,
  parameter int GAP_MID_RISE = 2,
  parameter int GAP_IN_RISE  = 2,
  parameter int GAP_IN_FALL  = 2,
  parameter int GAP_MID_FALL = 2,
  parameter int GAP_OUT_FALL = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SIG-1:0] rise_i,
  input  logic [NUM_SIG-1:0] fall_i,
  input  logic [1:0]         busy_lvl_i,  // {inner, mid} current levels
  input  logic [CNT_W-1:0]   count_i,
  output logic               clear_o,
  output logic               pass_o,
  output logic               err_o,
  output logic               abort_o,
  output logic [STEP_W-1:0]  err_step_o
);

  seq_state_e        state_q, state_d;
  logic              pass_q, pass_d, err_q, err_d, abort_q, abort_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [EV_W-1:0]   ev, seq_ev;
  logic [CNT_W:0]    elapsed;
  logic              on_time;

  function automatic int gap_of(seq_state_e s);
    case (s)
      ST_W_MID_R: gap_of = GAP_MID_RISE;
      ST_W_IN_R:  gap_of = GAP_IN_RISE;
      ST_W_IN_F:  gap_of = GAP_IN_FALL;
      ST_W_MID_F: gap_of = GAP_MID_FALL;
      ST_W_OUT_F: gap_of = GAP_OUT_FALL;
      default:    gap_of = 0;
    endcase
  endfunction

  assign ev      = {fall_i, rise_i};
  assign seq_ev  = ev & ~EV_W'(1);  // outer rise ignored mid-sequence
  assign elapsed = {1'b0, count_i} + 1'b1;
  assign on_time = int'(elapsed) >= gap_of(state_q);

  always_comb begin
    state_d = state_q;
    clear_o = 1'b0;
    pass_d  = 1'b0;
    err_d   = 1'b0;
    abort_d = 1'b0;
    step_d  = '0;
    if (state_q == ST_IDLE) begin
      if (ev[0] && (busy_lvl_i == 2'b00)) begin
        state_d = ST_W_MID_R;
        clear_o = 1'b1;
      end
    end else if (seq_ev != '0) begin
      if (seq_ev != expected_ev(state_q)) begin
        abort_d = 1'b1;
        state_d = ST_IDLE;
      end else if (!on_time) begin
        err_d   = 1'b1;
        step_d  = STEP_W'(state_q) - 1'b1;
        state_d = ST_IDLE;
      end else if (state_q == ST_W_OUT_F) begin
        pass_d  = 1'b1;
        state_d = ST_IDLE;
      end else begin
        state_d = seq_state_e'(state_q + 1'b1);
        clear_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pass_q  <= 1'b0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      err_q   <= err_d;
      abort_q <= abort_d;
      step_q  <= step_d;
    end
  end

  assign pass_o     = pass_q;
  assign err_o      = err_q;
  assign abort_o    = abort_q;
  assign err_step_o = step_q;

  a_r8_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pass_q, err_q, abort_q}));

  a_r8_pass_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_q |=> !pass_q);

  a_r8_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> !err_q);

  a_r3_err_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (state_q == ST_IDLE && step_q < STEP_W'(NUM_STEPS)));

  a_r6_idle_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !ev[0]) |=> (state_q == ST_IDLE && !pass_q && !err_q && !abort_q));

endmodule

// File: rtl/edge_seq_monitor.sv
`timescale 1ns/1ps
module edge_seq_monitor
  import edge_seq_pkg::*;
#(
  parameter int GAP_MID_RISE = 2,
  parameter int GAP_IN_RISE  = 2,
  parameter int GAP_IN_FALL  = 2,
  parameter int GAP_MID_FALL = 2,
  parameter int GAP_OUT_FALL = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        outer_i,
  input  logic        mid_i,
  input  logic        inner_i,
  output logic        pass_o,
  output logic        err_o,
  output logic        abort_o,
  output logic [2:0]  err_step_o
);

  localparam int MAX_A   = (GAP_MID_RISE > GAP_IN_RISE) ? GAP_MID_RISE : GAP_IN_RISE;
  localparam int MAX_B   = (GAP_IN_FALL > GAP_MID_FALL) ? GAP_IN_FALL : GAP_MID_FALL;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_GAP = (MAX_AB > GAP_OUT_FALL) ? MAX_AB : GAP_OUT_FALL;
  localparam int CNT_W   = $clog2(MAX_GAP + 1) + 1;

  logic [NUM_SIG-1:0] sig, rise, fall;
  logic [CNT_W-1:0]   count;
  logic               clear;

  assign sig = {inner_i, mid_i, outer_i};

  edge_seq_edge #(.WIDTH(NUM_SIG)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sig),
    .rise_o (rise),
    .fall_o (fall)
  );

  edge_seq_gap_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .count_o (count)
  );

  edge_seq_fsm #(
    .CNT_W        (CNT_W),
    .GAP_MID_RISE (GAP_MID_RISE),
    .GAP_IN_RISE  (GAP_IN_RISE),
    .GAP_IN_FALL  (GAP_IN_FALL),
    .GAP_MID_FALL (GAP_MID_FALL),
    .GAP_OUT_FALL (GAP_OUT_FALL)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (rise),
    .fall_i     (fall),
    .busy_lvl_i ({inner_i, mid_i}),
    .count_i    (count),
    .clear_o    (clear),
    .pass_o     (pass_o),
    .err_o      (err_o),
    .abort_o    (abort_o),
    .err_step_o (err_step_o)
  );

  a_r1_pass_after_outer_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (!$past(outer_i) && $past(outer_i, 2)));

  a_r3_step_zero_when_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o |-> (err_step_o == 3'd0));

endmodule

// File: tb/edge_seq_monitor_tb.sv
`timescale 1ns/1ps
module edge_seq_monitor_tb;

  localparam int G0 = 2, G1 = 2, G2 = 2, G3 = 2, G4 = 3;
  localparam int GAPS [5] = '{G0, G1, G2, G3, G4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic outer = 1'b0, mid = 1'b0, inner = 1'b0;
  logic pass_w, err_w, abort_w;
  logic [2:0] step_w;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  edge_seq_monitor #(
    .GAP_MID_RISE(G0), .GAP_IN_RISE(G1), .GAP_IN_FALL(G2),
    .GAP_MID_FALL(G3), .GAP_OUT_FALL(G4)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .outer_i(outer), .mid_i(mid), .inner_i(inner),
    .pass_o(pass_w), .err_o(err_w), .abort_o(abort_w), .err_step_o(step_w)
  );

  task automatic expect_out(input string req, input logic p, input logic e,
                            input logic a, input logic [2:0] st);
    checks++;
    if (pass_w !== p || err_w !== e || abort_w !== a || step_w !== st) begin
      errors++;
      $display("FAIL %s: got pass=%b err=%b abort=%b step=%0d, expected pass=%b err=%b abort=%b step=%0d",
               req, pass_w, err_w, abort_w, step_w, p, e, a, st);
    end
  endtask

  task automatic apply_edge(input int k);
    case (k)
      0: outer = 1'b1;
      1: mid   = 1'b1;
      2: inner = 1'b1;
      3: inner = 1'b0;
      4: mid   = 1'b0;
      default: outer = 1'b0;
    endcase
  endtask

  // change at the g-th negedge from now, then look just after the sampling edge
  task automatic step_to(input int k, input int g);
    repeat (g) @(negedge clk);
    apply_edge(k);
    @(posedge clk);
    #1;
  endtask

  task automatic cleanup(input string req);
    @(negedge clk);
    outer = 1'b0; mid = 1'b0; inner = 1'b0;
    @(posedge clk);
    #1;
    expect_out(req, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic run_seq(input string req, input int gp [5]);
    step_to(0, 2);
    expect_out(req, 0, 0, 0, 0);
    for (int s = 0; s < 5; s++) begin
      step_to(s + 1, gp[s]);
      if (gp[s] < GAPS[s]) begin
        expect_out({req, " R3 early"}, 0, 1, 0, 3'(s));
        @(posedge clk);
        #1;
        expect_out({req, " R8 err clears"}, 0, 0, 0, 0);
        cleanup({req, " R6 cleanup ignored"});
        return;
      end else if (s == 4) begin
        expect_out({req, " R1 pass"}, 1, 0, 0, 0);
      end else begin
        expect_out({req, " R2 step accepted"}, 0, 0, 0, 0);
      end
    end
    @(posedge clk);
    #1;
    expect_out({req, " R8 pass clears"}, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    #1;
  endtask

  initial begin
    // R9: reset with inputs already high
    outer = 1'b1; mid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R9 outputs low in reset", 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      #1;
      expect_out("R9 no edge from reset levels", 0, 0, 0, 0);
    end
    cleanup("R9 falls after reset ignored");

    // R1/R2/R3: sweep each step's gap around its limit
    for (int s = 0; s < 5; s++) begin
      for (int g = 1; g <= GAPS[s] + 1; g++) begin
        int gp [5];
        gp = GAPS;
        gp[s] = g;
        run_seq($sformatf("R2 sweep step %0d gap %0d", s, g), gp);
      end
    end

    // R1 mixed spacing, R7 very long gaps beyond counter range
    run_seq("R1 mixed gaps", '{5, 9, 3, 12, 4});
    run_seq("R7 saturating gaps", '{40, 33, 25, 50, 61});
    run_seq("R7 long then early", '{40, 33, 25, 50, 2});

    // R4: outer falls before mid rises
    step_to(0, 2);
    step_to(5, 3);
    expect_out("R4 outer fall before mid", 0, 0, 1, 0);
    @(posedge clk); #1;
    expect_out("R8 abort clears", 0, 0, 0, 0);
    cleanup("R4 cleanup");

    // R4: outer falls after mid, before inner
    step_to(0, 2); step_to(1, 3);
    step_to(5, 3);
    expect_out("R4 outer fall before inner", 0, 0, 1, 0);
    cleanup("R4 cleanup");

    // R4: mid falls before inner rises, even when early
    step_to(0, 2); step_to(1, 3);
    step_to(4, 1);
    expect_out("R4 mid fall before inner", 0, 0, 1, 0);
    cleanup("R4 cleanup");

    // R5: inner rises before mid
    step_to(0, 2);
    step_to(2, 3);
    expect_out("R5 inner before mid", 0, 0, 1, 0);
    cleanup("R5 cleanup");

    // R5: mid falls while inner high
    step_to(0, 2); step_to(1, 3); step_to(2, 3);
    step_to(4, 3);
    expect_out("R5 mid fall with inner high", 0, 0, 1, 0);
    cleanup("R5 cleanup");

    // R5: two inputs change together
    step_to(0, 2);
    repeat (3) @(negedge clk);
    mid = 1'b1; inner = 1'b1;
    @(posedge clk); #1;
    expect_out("R5 simultaneous change", 0, 0, 1, 0);
    cleanup("R5 cleanup");

    // R6: outer rise while mid high does not start
    @(negedge clk); mid = 1'b1;
    @(posedge clk); #1;
    expect_out("R6 mid rise in idle", 0, 0, 0, 0);
    step_to(0, 2);
    expect_out("R6 outer rise with mid high", 0, 0, 0, 0);
    step_to(2, 3);
    expect_out("R6 inner rise in idle", 0, 0, 0, 0);
    step_to(3, 3); step_to(4, 3); step_to(5, 3);
    expect_out("R6 no pass without start", 0, 0, 0, 0);
    repeat (2) @(posedge clk); #1;

    // still working afterwards
    run_seq("R1 after idle noise", GAPS);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule